// File: doc/BRIEF.md
# Nested Hardware Loop Sequencer

This block sequences zero-overhead loops for a small stack-oriented processor. The decoder sends it three commands: open a loop, test the end of a loop body, and abandon the innermost loop. It also sends the current program counter. The block answers in the same cycle with a redirect flag and a target address. Loop state lives in a private stack of entries. Each entry holds a remaining trip count, a body start address, an exit address and a one-bit kind tag. The stack is separate from the parameter and return stacks of the core.

The kind tag selects how iteration works. With tag 0 the body is one machine instruction: at every end test that is not the last, the block redirects to the current program counter, so the fetch stage reissues the same instruction. With tag 1 the body is a called threaded word: the end test is raised on the return from that word, and the block redirects to the stored start address. Opening a loop while another is active simply pushes a new entry on top, so the outer loop's state is kept without any software save. When the innermost loop finishes or is abandoned, the enclosing loop becomes the top again on the next cycle.

Top module: `hw_loop_seq`

## Requirements
- R1: After reset the loop stack is empty, and `taken_o`, `overflow_o` and `underflow_o` are 0. `redirect_pc_o` is 0 whenever `taken_o` is 0.
- R2: A `begin_i` command with a nonzero count and fewer than 8 stored entries pushes a new entry. It produces no redirect in that cycle.
- R3: A `check_i` command on an entry with tag 0 and a remaining count above 1 asserts `taken_o` with `redirect_pc_o` equal to `pc_i`, and decrements the count by one.
- R4: A `check_i` command on an entry with tag 1 and a remaining count above 1 asserts `taken_o` with `redirect_pc_o` equal to the entry's start address, and decrements the count.
- R5: A `check_i` command on an entry whose count is 1 pops that entry in the same cycle without a redirect. The enclosing entry is the top from the next cycle on.
- R6: A `begin_i` command with a count of 0 pushes nothing. It asserts `taken_o` with `redirect_pc_o` equal to the given exit address.
- R7: A `leave_i` command on a non-empty stack pops only the innermost entry. It asserts `taken_o` with `redirect_pc_o` equal to that entry's exit address, and the outer entries keep their state.
- R8: A `begin_i` command with a nonzero count while 8 entries are stored raises `overflow_o` for that cycle. No redirect is asserted and the stack is unchanged.
- R9: A `check_i` or `leave_i` command on an empty stack raises `underflow_o` for that cycle. No redirect is asserted and the stack stays empty.
- R10: Loops nest. The remaining count, start address, exit address and tag of every outer entry are unchanged while inner loops run.
- R11: When commands arrive together, `leave_i` wins over `check_i`, which wins over `begin_i`. The losing commands have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| leave_i | input | 1 | Abandon the innermost loop |
| check_i | input | 1 | End of loop body reached (reissue point or return from word) |
| begin_i | input | 1 | Open a new loop with the fields below |
| begin_count_i | input | 16 | Trip count of the new loop |
| begin_start_i | input | 16 | Body start address of the new loop |
| begin_exit_i | input | 16 | Address following the loop, used on leave and on a zero count |
| begin_mode_i | input | 1 | Kind tag: 0 single instruction, 1 threaded word |
| pc_i | input | 16 | Current program counter |
| taken_o | output | 1 | Redirect the fetch stage this cycle |
| redirect_pc_o | output | 16 | Redirect target, 0 when not taken |
| overflow_o | output | 1 | Begin refused because the stack is full |
| underflow_o | output | 1 | Check or leave issued on an empty stack |

## Verification
The assertions check on every cycle that the stored depth never exceeds 8, that a push never targets a full stack and a pop never an empty one, that an overflow or underflow leaves the depth unchanged with no redirect, and that a leave, a final check or an accepted begin moves the depth by exactly one. Whether the right address comes out, whether counts decrement correctly, and whether outer entries survive nesting can only be shown by the bench. It runs directed nesting, leave, overflow and priority scenarios, followed by a long random command stream, and compares every output against a queue-based model on each clock.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

  parameter int unsigned ADDR_W  = 16;
  parameter int unsigned COUNT_W = 16;

  typedef struct packed {
    logic [COUNT_W-1:0] count;
    logic [ADDR_W-1:0]  start_pc;
    logic [ADDR_W-1:0]  exit_pc;
    logic               is_word;
  } loop_entry_t;

endpackage

// File: rtl/hwloop_rst_sync.sv
module hwloop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/hwloop_stack.sv
module hwloop_stack
  import hwloop_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned DW   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_en_i,
  input  loop_entry_t        push_data_i,
  input  logic               pop_en_i,
  input  logic               dec_en_i,
  input  logic [COUNT_W-1:0] dec_count_i,
  output loop_entry_t        top_o,
  output logic [DW-1:0]      depth_o,
  output logic               empty_o,
  output logic               full_o
);

  loop_entry_t        slot_q [DEPTH];
  loop_entry_t        slot_d [DEPTH];
  logic [DEPTH-1:0]   slot_we;
  logic [DW-1:0]      depth_q;
  logic [DW-1:0]      depth_d;
  logic               depth_en;

  // Per-slot write enables: a push writes the first free slot, a count
  // update rewrites the current top slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic is_free_head;
    logic is_top;
    assign is_free_head = (depth_q == DW'(g));
    assign is_top       = (depth_q == DW'(g + 1));
    assign slot_we[g]   = (push_en_i && is_free_head) || (dec_en_i && is_top);
    always_comb begin
      slot_d[g] = slot_q[g];
      if (push_en_i && is_free_head) begin
        slot_d[g] = push_data_i;
      end else if (dec_en_i && is_top) begin
        slot_d[g].count = dec_count_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) begin
        slot_q[i] <= slot_d[i];
      end
    end
  end

  // Depth next state
  always_comb begin
    depth_en = push_en_i || pop_en_i;
    depth_d  = depth_q;
    if (push_en_i) begin
      depth_d = depth_q + DW'(1);
    end else if (pop_en_i) begin
      depth_d = depth_q - DW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
    end else if (depth_en) begin
      depth_q <= depth_d;
    end
  end

  // Top-of-stack read
  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (depth_q == DW'(i + 1)) begin
        top_o = slot_q[i];
      end
    end
  end

  assign depth_o = depth_q;
  assign empty_o = (depth_q == '0);
  assign full_o  = (depth_q == DW'(DEPTH));

  p_depth_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q <= DW'(DEPTH));

  p_no_push_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_en_i |-> (depth_q != DW'(DEPTH)));

  p_no_pop_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_en_i || dec_en_i) |-> (depth_q != '0));

  p_single_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({push_en_i, pop_en_i, dec_en_i}) <= 1);

endmodule

// File: rtl/hwloop_decide.sv
module hwloop_decide
  import hwloop_pkg::*;
(
  input  logic               leave_i,
  input  logic               check_i,
  input  logic               begin_i,
  input  logic [COUNT_W-1:0] begin_count_i,
  input  logic [ADDR_W-1:0]  begin_start_i,
  input  logic [ADDR_W-1:0]  begin_exit_i,
  input  logic               begin_mode_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  loop_entry_t        top_i,
  input  logic               empty_i,
  input  logic               full_i,
  output logic               push_en_o,
  output loop_entry_t        push_data_o,
  output logic               pop_en_o,
  output logic               dec_en_o,
  output logic [COUNT_W-1:0] dec_count_o,
  output logic               taken_o,
  output logic [ADDR_W-1:0]  redirect_pc_o,
  output logic               overflow_o,
  output logic               underflow_o
);

  logic more_trips;

  assign more_trips = (top_i.count > COUNT_W'(1));

  always_comb begin
    push_en_o     = 1'b0;
    pop_en_o      = 1'b0;
    dec_en_o      = 1'b0;
    dec_count_o   = top_i.count - COUNT_W'(1);
    taken_o       = 1'b0;
    redirect_pc_o = '0;
    overflow_o    = 1'b0;
    underflow_o   = 1'b0;
    push_data_o   = '{count:    begin_count_i,
                      start_pc: begin_start_i,
                      exit_pc:  begin_exit_i,
                      is_word:  begin_mode_i};

    if (leave_i) begin
      if (empty_i) begin
        underflow_o = 1'b1;
      end else begin
        pop_en_o      = 1'b1;
        taken_o       = 1'b1;
        redirect_pc_o = top_i.exit_pc;
      end
    end else if (check_i) begin
      if (empty_i) begin
        underflow_o = 1'b1;
      end else if (more_trips) begin
        dec_en_o      = 1'b1;
        taken_o       = 1'b1;
        redirect_pc_o = top_i.is_word ? top_i.start_pc : pc_i;
      end else begin
        pop_en_o = 1'b1;
      end
    end else if (begin_i) begin
      if (begin_count_i == '0) begin
        taken_o       = 1'b1;
        redirect_pc_o = begin_exit_i;
      end else if (full_i) begin
        overflow_o = 1'b1;
      end else begin
        push_en_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hw_loop_seq.sv
module hw_loop_seq
  import hwloop_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned DW   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               leave_i,
  input  logic               check_i,
  input  logic               begin_i,
  input  logic [COUNT_W-1:0] begin_count_i,
  input  logic [ADDR_W-1:0]  begin_start_i,
  input  logic [ADDR_W-1:0]  begin_exit_i,
  input  logic               begin_mode_i,
  input  logic [ADDR_W-1:0]  pc_i,
  output logic               taken_o,
  output logic [ADDR_W-1:0]  redirect_pc_o,
  output logic               overflow_o,
  output logic               underflow_o
);

  logic               rst_n_s;
  logic               push_en;
  loop_entry_t        push_data;
  logic               pop_en;
  logic               dec_en;
  logic [COUNT_W-1:0] dec_count;
  loop_entry_t        top_entry;
  logic [DW-1:0]      depth;
  logic               empty;
  logic               full;

  hwloop_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  hwloop_decide u_decide (
    .leave_i       (leave_i),
    .check_i       (check_i),
    .begin_i       (begin_i),
    .begin_count_i (begin_count_i),
    .begin_start_i (begin_start_i),
    .begin_exit_i  (begin_exit_i),
    .begin_mode_i  (begin_mode_i),
    .pc_i          (pc_i),
    .top_i         (top_entry),
    .empty_i       (empty),
    .full_i        (full),
    .push_en_o     (push_en),
    .push_data_o   (push_data),
    .pop_en_o      (pop_en),
    .dec_en_o      (dec_en),
    .dec_count_o   (dec_count),
    .taken_o       (taken_o),
    .redirect_pc_o (redirect_pc_o),
    .overflow_o    (overflow_o),
    .underflow_o   (underflow_o)
  );

  hwloop_stack #(.DEPTH(DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .push_en_i   (push_en),
    .push_data_i (push_data),
    .pop_en_i    (pop_en),
    .dec_en_i    (dec_en),
    .dec_count_i (dec_count),
    .top_o       (top_entry),
    .depth_o     (depth),
    .empty_o     (empty),
    .full_o      (full)
  );

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !taken_o |-> (redirect_pc_o == '0));

  p_push_grows_r2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (begin_i && !leave_i && !check_i && begin_count_i != '0 && !overflow_o)
      |=> (depth == $past(depth) + DW'(1)));

  p_final_pops_r5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (check_i && !leave_i && !underflow_o && !taken_o)
      |=> (depth == $past(depth) - DW'(1)));

  p_zero_skip_r6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (begin_i && !leave_i && !check_i && begin_count_i == '0)
      |=> $stable(depth));

  p_leave_one_r7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (leave_i && !underflow_o) |=> (depth == $past(depth) - DW'(1)));

  p_ovf_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    overflow_o |-> (!taken_o ##1 $stable(depth)));

  p_unf_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    underflow_o |-> (!taken_o && depth == '0));

  p_flags_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $onehot0({overflow_o, underflow_o}));

endmodule

// File: tb/hw_loop_seq_tb_top.sv
module hw_loop_seq_tb_top;

  logic        clk;
  logic        rst_n;
  logic        leave, check, beg, mode;
  logic [15:0] cnt, start, ex, pc;
  logic        taken, ovf, unf;
  logic [15:0] rpc;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference model: one queue per field, back is the innermost loop.
  int q_cnt[$];
  int q_start[$];
  int q_exit[$];
  int q_mode[$];

  hw_loop_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .leave_i(leave), .check_i(check),
    .begin_i(beg), .begin_count_i(cnt), .begin_start_i(start),
    .begin_exit_i(ex), .begin_mode_i(mode), .pc_i(pc),
    .taken_o(taken), .redirect_pc_o(rpc), .overflow_o(ovf), .underflow_o(unf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic step(string tag, bit lv, bit ck, bit bg, int c, int s, int e,
                      bit m, int p);
    bit e_t, e_o, e_u;
    int e_pc, n;
    leave = lv; check = ck; beg = bg;
    cnt = 16'(c); start = 16'(s); ex = 16'(e); mode = m; pc = 16'(p);
    #2;
    e_t = 0; e_o = 0; e_u = 0; e_pc = 0;
    n = q_cnt.size();
    if (lv) begin
      if (n == 0) e_u = 1;
      else begin
        e_t = 1; e_pc = q_exit[n-1];
        void'(q_cnt.pop_back()); void'(q_start.pop_back());
        void'(q_exit.pop_back()); void'(q_mode.pop_back());
      end
    end else if (ck) begin
      if (n == 0) e_u = 1;
      else if (q_cnt[n-1] > 1) begin
        e_t = 1; e_pc = (q_mode[n-1] != 0) ? q_start[n-1] : p;
        q_cnt[n-1] = q_cnt[n-1] - 1;
      end else begin
        void'(q_cnt.pop_back()); void'(q_start.pop_back());
        void'(q_exit.pop_back()); void'(q_mode.pop_back());
      end
    end else if (bg) begin
      if (c == 0) begin e_t = 1; e_pc = e; end
      else if (n == 8) e_o = 1;
      else begin
        q_cnt.push_back(c); q_start.push_back(s);
        q_exit.push_back(e); q_mode.push_back(int'(m));
      end
    end
    checks++;
    if (taken !== e_t || rpc !== 16'(e_pc) || ovf !== e_o || unf !== e_u) begin
      errors++;
      $display("FAIL %s: actual taken=%b pc=%h ovf=%b unf=%b expected taken=%b pc=%h ovf=%b unf=%b",
               tag, taken, rpc, ovf, unf, e_t, 16'(e_pc), e_o, e_u);
    end
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 16'h0040);
  endtask

  initial begin
    rst_n = 1'b0;
    leave = 0; check = 0; beg = 0; mode = 0;
    cnt = '0; start = '0; ex = '0; pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    idle("R1");
    // R9: empty stack
    step("R9", 0, 1, 0, 0, 0, 0, 0, 16'h0010);
    step("R9", 1, 0, 0, 0, 0, 0, 0, 16'h0010);
    // R6: zero count skip
    step("R6", 0, 0, 1, 0, 16'h0100, 16'h0180, 1, 16'h00FF);
    step("R9", 0, 1, 0, 0, 0, 0, 0, 16'h0101);
    // R2/R3/R5: single instruction loop of 3
    step("R2", 0, 0, 1, 3, 16'h0100, 16'h0101, 0, 16'h00FF);
    step("R3", 0, 1, 0, 0, 0, 0, 0, 16'h0100);
    step("R3", 0, 1, 0, 0, 0, 0, 0, 16'h0100);
    step("R5", 0, 1, 0, 0, 0, 0, 0, 16'h0100);
    step("R5", 0, 1, 0, 0, 0, 0, 0, 16'h0101);
    // R4: threaded word loop of 2
    step("R2", 0, 0, 1, 2, 16'h0200, 16'h0210, 1, 16'h01FF);
    step("R4", 0, 1, 0, 0, 0, 0, 0, 16'h0900);
    step("R5", 0, 1, 0, 0, 0, 0, 0, 16'h0900);
    // R10: nesting
    step("R10", 0, 0, 1, 2, 16'h0300, 16'h0320, 1, 16'h02FF);
    step("R10", 0, 0, 1, 2, 16'h0305, 16'h0306, 0, 16'h0304);
    step("R10", 0, 1, 0, 0, 0, 0, 0, 16'h0305);
    step("R10", 0, 1, 0, 0, 0, 0, 0, 16'h0305);
    step("R10", 0, 1, 0, 0, 0, 0, 0, 16'h0A00);
    step("R10", 0, 1, 0, 0, 0, 0, 0, 16'h0A00);
    // R7: leave innermost only
    step("R7", 0, 0, 1, 5, 16'h0400, 16'h0440, 1, 16'h03FF);
    step("R7", 0, 0, 1, 9, 16'h0410, 16'h0420, 0, 16'h040F);
    step("R7", 1, 0, 0, 0, 0, 0, 0, 16'h0410);
    step("R7", 0, 1, 0, 0, 0, 0, 0, 16'h0B00);
    step("R7", 1, 0, 0, 0, 0, 0, 0, 16'h0400);
    step("R9", 1, 0, 0, 0, 0, 0, 0, 16'h0440);
    // R8: overflow
    for (int i = 0; i < 8; i++) step("R8", 0, 0, 1, i + 2, 16'h0500 + i, 16'h0600 + i, i[0], 16'h04FF);
    step("R8", 0, 0, 1, 4, 16'h0700, 16'h0710, 0, 16'h06FF);
    step("R8", 0, 0, 1, 0, 16'h0700, 16'h0711, 0, 16'h06FF);
    step("R8", 0, 1, 0, 0, 0, 0, 0, 16'h0507);
    for (int i = 0; i < 8; i++) step("R8", 1, 0, 0, 0, 0, 0, 0, 16'h0500);
    step("R9", 0, 1, 0, 0, 0, 0, 0, 16'h0500);
    // R11: priority
    step("R11", 0, 0, 1, 3, 16'h0800, 16'h0810, 1, 16'h07FF);
    step("R11", 1, 1, 1, 4, 16'h0900, 16'h0910, 0, 16'h0805);
    step("R11", 0, 1, 1, 0, 16'h0900, 16'h0911, 0, 16'h0805);
    step("R11", 0, 1, 1, 2, 16'h0A00, 16'h0A10, 1, 16'h0805);
    step("R11", 1, 1, 0, 0, 0, 0, 0, 16'h0805);
    // Random command stream
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step("R10", r < 8, (r >= 8 && r < 50) || r > 95, r >= 45,
           int'($urandom_range(0, 3)), int'($urandom_range(0, 65535)),
           int'($urandom_range(0, 65535)), bit'($urandom_range(0, 1)),
           int'($urandom_range(0, 65535)));
    end
    idle("R1");

    done = 1;
    summary();
    $finish;
  end

endmodule